// File: doc/BRIEF.md
# Segment Address Checker

This block sits on the memory access path and turns a segment-relative access into a linear address. Each request carries a segment register number, a 32-bit offset, an access size and an access kind. It also carries the cached base, limit and attribute bits that the core holds for that register. The block checks the access against the scaled limit and against the permissions that the segment type grants. It then returns either the linear address or a fault class, one clock after the request.

Two kinds of data segment are handled. A normal segment allows the offsets from zero up to its limit. An expand-down segment allows the offsets above its limit, up to a ceiling picked by the default-size bit. A mode input switches the block to flat 64-bit behaviour. In that mode limits and the unusable flag are ignored, and every base is forced to zero except for the two thread-local registers. Those two take their base from a separate 64-bit input.

Top module: `seg_xlate`

## Requirements
- R1: `rspValid` is high in the cycle after each cycle in which `reqValid` is high, and low in the cycle after each cycle in which `reqValid` is low. Fault class and address are registered in that same cycle.
- R2: With `flatMode` low and no fault, `linAddr` is `(segBase + offset) mod 2^32`, zero-extended to 64 bits.
- R3: With `gran` high, the effective limit is `{segLimit, 12'hFFF}`. With `gran` low it is `segLimit` in bytes.
- R4: For a normal segment, an access is in bounds only if `offset + size - 1 <= effective limit`, computed without wraparound. `accSize` 0, 1 and 2 mean 1, 2 and 4 bytes, and 3 also means 4 bytes.
- R5: For an expand-down data segment (`segType[2]`=0, `segType[1]`=1), an access is in bounds only if `offset > effective limit` and `offset + size - 1` does not exceed the ceiling. The ceiling is 0xFFFFFFFF when `bigDef`=1 and 0xFFFF when `bigDef`=0.
- R6: `segType[2]`=1 marks code and `segType[0]` is the readable (code) or writable (data) bit. `accKind` is 0 read, 1 write, 2 execute, and 3 behaves as read. The following accesses raise a general-protection fault on any register and in either mode: a write to code, a write to data with `segType[0]`=0, a read of code with `segType[0]`=0, and an execute from data.
- R7: With `flatMode` low, an access through a register whose `unusable` flag is set gives a general-protection fault, even through the stack register.
- R8: `faultClass` is 0 for none, 1 for general protection and 2 for stack; the value 3 never appears. A bound violation through register 2 (stack) gives class 2. Through any other register (0 ES, 1 CS, 3 DS, 4 FS, 5 GS, 6 and 7 generic) it gives class 1. A permission or unusable fault wins over a bound violation.
- R9: With `flatMode` high, no bound check is made and `unusable` is ignored. For registers other than 4 and 5, `linAddr` is the offset zero-extended and `segBase` has no effect.
- R10: With `flatMode` high, registers 4 and 5 give `linAddr = (wideBase + offset) mod 2^64`. With `flatMode` low these two registers use `segBase` like any other register, and `wideBase` has no effect.
- R11: Whenever a registered response carries a fault, `linAddr` is zero.
- R12: After reset, `rspValid`, `faultClass` and `linAddr` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Request present this cycle |
| segSel | input | 3 | Segment register number (2 = stack, 4/5 = thread-local) |
| offset | input | 32 | Offset within the segment |
| accSize | input | 2 | Access size code |
| accKind | input | 2 | Read, write or execute |
| flatMode | input | 1 | Flat 64-bit behaviour |
| segBase | input | 32 | Cached segment base |
| segLimit | input | 20 | Cached raw segment limit |
| gran | input | 1 | Limit counted in 4 KB units |
| bigDef | input | 1 | Default-size bit (expand-down ceiling) |
| segType | input | 3 | Code flag, expand-down flag, readable/writable flag |
| unusable | input | 1 | Register was loaded with a null selector |
| wideBase | input | 64 | 64-bit thread-local base for flat mode |
| rspValid | output | 1 | Response present |
| faultClass | output | 2 | Fault class of the response |
| linAddr | output | 64 | Linear address of the response |

## Verification
The bench builds the block with its default parameters: a 32-bit offset, a 20-bit raw limit with a 12-bit granularity shift, a 16-bit small ceiling and a 64-bit wide base. These values bring several corner cases within reach. The scaled limit can reach 0xFFFFFFFF, so an access of the last bytes of the 4 GB space must fault and must not wrap. The 16-bit expand-down ceiling can be probed one byte past its edge, and the 64-bit thread-local sum can be made to wrap. Each bound is tested at the last legal byte and one byte beyond it.

// File: rtl/seg_pkg.sv
package seg_pkg;

  localparam logic [1:0] FLT_NONE = 2'd0;
  localparam logic [1:0] FLT_GP   = 2'd1;
  localparam logic [1:0] FLT_SS   = 2'd2;

  localparam logic [1:0] ACC_WR = 2'd1;
  localparam logic [1:0] ACC_EX = 2'd2;

  localparam logic [2:0] SEL_SS = 3'd2;
  localparam logic [2:0] SEL_FS = 3'd4;
  localparam logic [2:0] SEL_GS = 3'd5;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;    // register a response this cycle
    logic checkLimit; // apply bound check
    logic expandDown; // inverted bounds
    logic wideUpper;  // expand-down ceiling is full width
    logic useWide;    // take the 64-bit base
    logic keepBase;   // add the cached base
    logic genFault;   // permission or unusable fault
    logic stackSel;   // access goes through the stack register
  } ctrl_strobe_t;

endpackage

// File: rtl/seg_ctrl.sv
module seg_ctrl
  import seg_pkg::*;
(
  input  logic         reqValid,
  input  logic [2:0]   segSel,
  input  logic [1:0]   accKind,
  input  logic         flatMode,
  input  logic         bigDef,
  input  logic [2:0]   segType,
  input  logic         unusable,
  output ctrl_strobe_t strb
);

  logic codeSeg, rwBit, isWrite, isExec, isRead;
  logic typeFault, threadReg;

  always_comb begin
    codeSeg   = segType[2];
    rwBit     = segType[0];
    isWrite   = (accKind == ACC_WR);
    isExec    = (accKind == ACC_EX);
    isRead    = !isWrite && !isExec;
    threadReg = (segSel == SEL_FS) || (segSel == SEL_GS);

    typeFault = (isWrite && (codeSeg || !rwBit))
              || (isExec && !codeSeg)
              || (isRead && codeSeg && !rwBit);

    strb.capture    = reqValid;
    strb.checkLimit = !flatMode;
    strb.expandDown = !flatMode && !codeSeg && segType[1];
    strb.wideUpper  = bigDef;
    strb.useWide    = flatMode && threadReg;
    strb.keepBase   = !flatMode;
    strb.genFault   = typeFault || (unusable && !flatMode);
    strb.stackSel   = (segSel == SEL_SS);
  end

endmodule

// File: rtl/seg_dp.sv
module seg_dp
  import seg_pkg::*;
#(
  parameter int OFF_W   = 32,
  parameter int LIM_W   = 20,
  parameter int GRAN_SH = 12,
  parameter int SMALL_W = 16,
  parameter int WIDE_W  = 64
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrl_strobe_t       strb,
  input  logic [OFF_W-1:0]   offset,
  input  logic [1:0]         accSize,
  input  logic [OFF_W-1:0]   segBase,
  input  logic [LIM_W-1:0]   segLimit,
  input  logic               gran,
  input  logic [WIDE_W-1:0]  wideBase,
  output logic               rspValid,
  output logic [1:0]         faultClass,
  output logic [WIDE_W-1:0]  linAddr
);

  localparam int SCALED_W = LIM_W + GRAN_SH;
  localparam int EXT_W    = OFF_W + 1;

  logic [SCALED_W-1:0] scaledLim;
  logic [OFF_W-1:0]    effLim, ceilLim, legacySum;
  logic [EXT_W-1:0]    sizeM1, lastByte;
  logic                normOk, edOk, limOk;
  logic [WIDE_W-1:0]   wideSum, addrNext;
  logic [1:0]          faultNext;

  always_comb begin
    case (accSize)
      2'd0:    sizeM1 = EXT_W'(0);
      2'd1:    sizeM1 = EXT_W'(1);
      default: sizeM1 = EXT_W'(3);
    endcase
    lastByte  = {1'b0, offset} + sizeM1;

    scaledLim = {segLimit, {GRAN_SH{1'b1}}};
    effLim    = gran ? OFF_W'(scaledLim) : OFF_W'(segLimit);
    ceilLim   = strb.wideUpper ? {OFF_W{1'b1}} : OFF_W'({SMALL_W{1'b1}});

    normOk = lastByte <= {1'b0, effLim};
    edOk   = (offset > effLim) && (lastByte <= {1'b0, ceilLim});
    limOk  = !strb.checkLimit || (strb.expandDown ? edOk : normOk);

    legacySum = segBase + offset;
    wideSum   = wideBase + WIDE_W'(offset);
    if (strb.useWide)       addrNext = wideSum;
    else if (strb.keepBase) addrNext = WIDE_W'(legacySum);
    else                    addrNext = WIDE_W'(offset);

    if (strb.genFault)  faultNext = FLT_GP;
    else if (!limOk)    faultNext = strb.stackSel ? FLT_SS : FLT_GP;
    else                faultNext = FLT_NONE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid   <= 1'b0;
      faultClass <= FLT_NONE;
      linAddr    <= '0;
    end else begin
      rspValid <= strb.capture;
      if (strb.capture) begin
        faultClass <= faultNext;
        linAddr    <= (faultNext == FLT_NONE) ? addrNext : '0;
      end
    end
  end

endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_pkg::*;
#(
  parameter int OFF_W   = 32,
  parameter int LIM_W   = 20,
  parameter int GRAN_SH = 12,
  parameter int SMALL_W = 16,
  parameter int WIDE_W  = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [2:0]        segSel,
  input  logic [OFF_W-1:0]  offset,
  input  logic [1:0]        accSize,
  input  logic [1:0]        accKind,
  input  logic              flatMode,
  input  logic [OFF_W-1:0]  segBase,
  input  logic [LIM_W-1:0]  segLimit,
  input  logic              gran,
  input  logic              bigDef,
  input  logic [2:0]        segType,
  input  logic              unusable,
  input  logic [WIDE_W-1:0] wideBase,
  output logic              rspValid,
  output logic [1:0]        faultClass,
  output logic [WIDE_W-1:0] linAddr
);

  ctrl_strobe_t strb;

  seg_ctrl u_ctrl (
    .reqValid (reqValid),
    .segSel   (segSel),
    .accKind  (accKind),
    .flatMode (flatMode),
    .bigDef   (bigDef),
    .segType  (segType),
    .unusable (unusable),
    .strb     (strb)
  );

  seg_dp #(
    .OFF_W   (OFF_W),
    .LIM_W   (LIM_W),
    .GRAN_SH (GRAN_SH),
    .SMALL_W (SMALL_W),
    .WIDE_W  (WIDE_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .offset     (offset),
    .accSize    (accSize),
    .segBase    (segBase),
    .segLimit   (segLimit),
    .gran       (gran),
    .wideBase   (wideBase),
    .rspValid   (rspValid),
    .faultClass (faultClass),
    .linAddr    (linAddr)
  );

endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
  parameter int OFF_W  = 32,
  parameter int WIDE_W = 64
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic [2:0]        segSel,
  input logic [OFF_W-1:0]  offset,
  input logic [1:0]        accKind,
  input logic              flatMode,
  input logic              codeSeg,
  input logic              unusable,
  input logic              rspValid,
  input logic [1:0]        faultClass,
  input logic [WIDE_W-1:0] linAddr
);

  p_latency_r1: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);

  p_idle_r1: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid);

  p_class_legal_r8: assert property (@(posedge clk) disable iff (!rstN)
    faultClass != 2'd3);

  p_stack_class_r8: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && segSel != 3'd2 |=> faultClass != 2'd2);

  p_fault_addr_zero_r11: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && faultClass != 2'd0 |-> linAddr == '0);

  p_unusable_gp_r7: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && !flatMode && unusable |=> faultClass == 2'd1);

  p_code_write_r6: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && accKind == 2'd1 && codeSeg |=> faultClass == 2'd1);

  p_flat_zero_base_r9: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && flatMode && segSel == 3'd3 && accKind == 2'd0 && !codeSeg
    |=> faultClass == 2'd0 && linAddr == WIDE_W'($past(offset)));

endmodule

bind seg_xlate seg_xlate_chk #(.OFF_W(OFF_W), .WIDE_W(WIDE_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .reqValid   (reqValid),
  .segSel     (segSel),
  .offset     (offset),
  .accKind    (accKind),
  .flatMode   (flatMode),
  .codeSeg    (segType[2]),
  .unusable   (unusable),
  .rspValid   (rspValid),
  .faultClass (faultClass),
  .linAddr    (linAddr)
);

// File: tb/sim_seg_xlate.sv
module sim_seg_xlate;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [2:0]  segSel = 3'd3;
  logic [31:0] offset = '0;
  logic [1:0]  accSize = 2'd0;
  logic [1:0]  accKind = 2'd0;
  logic        flatMode = 1'b0;
  logic [31:0] segBase = '0;
  logic [19:0] segLimit = '0;
  logic        gran = 1'b0;
  logic        bigDef = 1'b0;
  logic [2:0]  segType = 3'b001;
  logic        unusable = 1'b0;
  logic [63:0] wideBase = '0;
  logic        rspValid;
  logic [1:0]  faultClass;
  logic [63:0] linAddr;

  int testCount = 0;
  int failCount = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  seg_xlate u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .segSel(segSel),
    .offset(offset), .accSize(accSize), .accKind(accKind),
    .flatMode(flatMode), .segBase(segBase), .segLimit(segLimit),
    .gran(gran), .bigDef(bigDef), .segType(segType), .unusable(unusable),
    .wideBase(wideBase), .rspValid(rspValid), .faultClass(faultClass),
    .linAddr(linAddr)
  );

  task automatic setDefaults();
    segSel = 3'd3; offset = '0; accSize = 2'd2; accKind = 2'd0;
    flatMode = 1'b0; segBase = '0; segLimit = 20'hFFFFF; gran = 1'b1;
    bigDef = 1'b1; segType = 3'b001; unusable = 1'b0; wideBase = '0;
  endtask

  // one access: request on a negedge, response sampled one cycle later
  task automatic runCheck(string tag, logic [1:0] expCls, logic [63:0] expAddr);
    @(negedge clk);
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    testCount++;
    if (rspValid !== 1'b1 || faultClass !== expCls || linAddr !== expAddr) begin
      failCount++;
      $display("FAIL %s: valid=%0b class=%0d addr=%h expected valid=1 class=%0d addr=%h",
               tag, rspValid, faultClass, linAddr, expCls, expAddr);
    end
  endtask

  task automatic testReset();
    testCount++;
    if (rspValid !== 1'b0 || faultClass !== 2'd0 || linAddr !== '0) begin
      failCount++;
      $display("FAIL R12: valid=%0b class=%0d addr=%h expected 0 0 0",
               rspValid, faultClass, linAddr);
    end
  endtask

  task automatic testIdle();
    setDefaults();
    runCheck("R1 single access", 2'd0, 64'h0);
    @(negedge clk);
    testCount++;
    if (rspValid !== 1'b0) begin
      failCount++;
      $display("FAIL R1: idle valid=%0b expected 0", rspValid);
    end
  endtask

  task automatic testWrapAdd();
    setDefaults();
    segBase = 32'hFFFF_F000; offset = 32'h0000_2000;
    runCheck("R2 base+offset wrap", 2'd0, 64'h0000_0000_0000_1000);
  endtask

  task automatic testNormalBound();
    setDefaults();
    segBase = 32'h1000; segLimit = 20'h00100; gran = 1'b0;
    offset = 32'hFD;
    runCheck("R4 last legal dword", 2'd0, 64'h10FD);
    offset = 32'hFE;
    runCheck("R4 one past limit", 2'd1, 64'h0);
    offset = 32'h100; accSize = 2'd0;
    runCheck("R4 byte at limit", 2'd0, 64'h1100);
    offset = 32'h100; accSize = 2'd1;
    runCheck("R4 word over limit", 2'd1, 64'h0);
    segBase = '0; segLimit = 20'hFFFFF; gran = 1'b1;
    offset = 32'hFFFF_FFFF; accSize = 2'd1;
    runCheck("R4 no wrap at top", 2'd1, 64'h0);
  endtask

  task automatic testGranularity();
    setDefaults();
    segLimit = 20'h00001; accSize = 2'd0;
    offset = 32'h1FFF;
    runCheck("R3 scaled last byte", 2'd0, 64'h1FFF);
    offset = 32'h2000;
    runCheck("R3 scaled past limit", 2'd1, 64'h0);
    gran = 1'b0; offset = 32'h2;
    runCheck("R3 byte limit", 2'd1, 64'h0);
  endtask

  task automatic testExpandDown();
    setDefaults();
    segType = 3'b011; segLimit = 20'h00FFF; gran = 1'b0; bigDef = 1'b0;
    segBase = 32'h10000; accSize = 2'd0;
    offset = 32'h0FFF;
    runCheck("R5 offset at limit", 2'd1, 64'h0);
    offset = 32'h1000;
    runCheck("R5 just above limit", 2'd0, 64'h11000);
    offset = 32'hFFFE; accSize = 2'd2;
    runCheck("R5 past small ceiling", 2'd1, 64'h0);
    bigDef = 1'b1;
    runCheck("R5 wide ceiling", 2'd0, 64'h1FFFE);
  endtask

  task automatic testStackClass();
    setDefaults();
    segSel = 3'd2; segType = 3'b011; segLimit = 20'h00FFF; gran = 1'b0;
    offset = 32'h10;
    runCheck("R8 stack expand-down", 2'd2, 64'h0);
    segType = 3'b001; offset = 32'h2000;
    runCheck("R8 stack normal", 2'd2, 64'h0);
    segSel = 3'd0;
    runCheck("R8 non-stack", 2'd1, 64'h0);
  endtask

  task automatic testPermissions();
    setDefaults();
    segBase = 32'h40; offset = 32'h8;
    segType = 3'b101; accKind = 2'd1;
    runCheck("R6 write code", 2'd1, 64'h0);
    segType = 3'b000;
    runCheck("R6 write read-only data", 2'd1, 64'h0);
    segType = 3'b100; accKind = 2'd0;
    runCheck("R6 read exec-only code", 2'd1, 64'h0);
    segType = 3'b001; accKind = 2'd2;
    runCheck("R6 exec data", 2'd1, 64'h0);
    segType = 3'b100;
    runCheck("R6 exec code", 2'd0, 64'h48);
    segType = 3'b101; accKind = 2'd0;
    runCheck("R6 read readable code", 2'd0, 64'h48);
    segSel = 3'd2; segType = 3'b000; accKind = 2'd1; offset = 32'hFFFF_FFFF;
    runCheck("R6 perm fault on stack is GP", 2'd1, 64'h0);
    flatMode = 1'b1; segSel = 3'd1; segType = 3'b101; offset = 32'h8;
    runCheck("R6 flat write code", 2'd1, 64'h0);
  endtask

  task automatic testUnusable();
    setDefaults();
    unusable = 1'b1;
    runCheck("R7 unusable data", 2'd1, 64'h0);
    segSel = 3'd2;
    runCheck("R7 unusable stack", 2'd1, 64'h0);
  endtask

  task automatic testFlat();
    setDefaults();
    flatMode = 1'b1; segBase = 32'h1234_0000; segLimit = '0; gran = 1'b0;
    offset = 32'h8000_0000;
    runCheck("R9 flat ignores base and limit", 2'd0, 64'h0000_0000_8000_0000);
    unusable = 1'b1; segSel = 3'd2; offset = 32'h44;
    runCheck("R9 flat ignores unusable", 2'd0, 64'h44);
  endtask

  task automatic testThreadBase();
    setDefaults();
    flatMode = 1'b1; segSel = 3'd4;
    wideBase = 64'hFFFF_FFFF_FFFF_FFF0; offset = 32'h20;
    runCheck("R10 FS wide wrap", 2'd0, 64'h10);
    segSel = 3'd5; wideBase = 64'h0000_7000_0000_0000; offset = 32'h10;
    runCheck("R10 GS wide base", 2'd0, 64'h0000_7000_0000_0010);
    flatMode = 1'b0; segSel = 3'd4; segBase = 32'h100; offset = 32'h4;
    runCheck("R10 legacy FS ignores wide base", 2'd0, 64'h104);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testIdle();
    testWrapAdd();
    testNormalBound();
    testGranularity();
    testExpandDown();
    testStackClass();
    testPermissions();
    testUnusable();
    testFlat();
    testThreadBase();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failCount++;
      $display("FAIL watchdog: run did not complete");
      $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

endmodule